// File: doc/BRIEF.md
# Lane-wise vector interleave unit

This block is a permute datapath for vectors of fixed-width elements, one clock deep. The vector is cut into lanes of four elements. In each lane the unit takes the two lowest elements of the first source and the two lowest elements of the second source and alternates them, starting with the first source. The two highest elements of each lane, in both sources, take no part in the result. The second source may be replaced by a copy of its element 0 in every position. A per-element write mask then either keeps the old destination value or clears the element. Elements beyond the requested vector length are cleared.

A separate compatibility mode handles a 128-bit-only form. In this mode only lane 0 is produced, and every element above lane 0 is taken unchanged from the old destination.

A small controller has two states:
- `ST_IDLE`: no result is presented.
- `ST_SHOW`: a result is presented.

On every clock the controller goes to `ST_SHOW` when `in_valid` is high and to `ST_IDLE` when it is low, whichever state it is in. This applies to both transitions, `ST_IDLE`→`ST_SHOW` and `ST_SHOW`→`ST_IDLE`, and to staying in either state. `out_valid` is high exactly in `ST_SHOW`.

Top module: `lvi_unit`

## Requirements
- R1: Within lane L, output elements 4L, 4L+1, 4L+2 and 4L+3 are, in that order, `src_a` element 4L, `src_b` element 4L, `src_a` element 4L+1 and `src_b` element 4L+1. Element e occupies bits [e*ELEM_W +: ELEM_W].
- R2: Elements 4L+2 and 4L+3 of `src_a` and `src_b` never affect the output.
- R3: With `bcast`=1 (and `legacy`=0), every second-source element used is `src_b` element 0.
- R4: With `mask_en`=1, an active element whose `wmask` bit is 1 takes the interleaved value. An active element whose bit is 0 keeps `old_dst` when `zero_sel`=0.
- R5: With `mask_en`=1 and `zero_sel`=1, an active element whose `wmask` bit is 0 becomes zero.
- R6: `len_code` sets the number of active lanes, limited to NUM_LANES: 00 gives 1 lane, 01 gives 2, 10 gives 4 and 11 gives NUM_LANES. With `legacy`=0, every element in an inactive lane is zero. With `mask_en`=0, every active element takes the interleaved value.
- R7: `wmask` bits of elements in inactive lanes have no effect.
- R8: With `legacy`=1, elements 0–3 take the R1 result, with `mask_en`, `zero_sel`, `bcast` and `len_code` ignored. All elements from 4 upward equal `old_dst`.
- R9: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared on that edge.
- R10: Inputs with `in_valid`=1 produce `out_data` and `out_valid`=1 after that edge. After an edge with `in_valid`=0, `out_valid` is 0 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | inputs valid this cycle |
| src_a | input | NUM_LANES*4*ELEM_W | first source vector |
| src_b | input | NUM_LANES*4*ELEM_W | second source vector |
| old_dst | input | NUM_LANES*4*ELEM_W | previous destination value |
| wmask | input | NUM_LANES*4 | per-element write mask |
| mask_en | input | 1 | apply write mask |
| zero_sel | input | 1 | 1: clear unmasked elements, 0: keep old value |
| bcast | input | 1 | replicate `src_b` element 0 |
| len_code | input | 2 | vector length in lanes |
| legacy | input | 1 | 128-bit compatibility mode |
| out_valid | output | 1 | result valid |
| out_data | output | NUM_LANES*4*ELEM_W | registered result |

## Verification
The bench builds the unit with ELEM_W=8 and NUM_LANES=4. This keeps the full 16-element structure, with its four lanes, every length code including the clipped 11, and both upper-bit policies, at a width where each element's value is easy to read. At that size the sweep covers every combination of length, mode, broadcast, mask enable and zero select under eight mask patterns. Directed cases cover junk in the ignored upper elements, mask bits above the active length, latency, hold and reset.

// File: rtl/lvi_pkg.sv
package lvi_pkg;

    localparam int unsigned LANE_EL = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ctl_state_e;

    // number of active lanes for a length code, clipped to the build size
    function automatic int unsigned lanes_for(input logic [1:0] code,
                                              input int unsigned max_lanes);
        int unsigned n;
        unique case (code)
            2'b00:   n = 1;
            2'b01:   n = 2;
            2'b10:   n = 4;
            default: n = max_lanes;
        endcase
        return (n > max_lanes) ? max_lanes : n;
    endfunction

endpackage

// File: rtl/lvi_src_prep.sv
module lvi_src_prep #(
    parameter int unsigned ELEM_W = 32,
    parameter int unsigned NUM_EL = 16
) (
    input  logic [NUM_EL*ELEM_W-1:0] src_b,
    input  logic                     bcast,
    output logic [NUM_EL*ELEM_W-1:0] src_b_eff
);

    for (genvar e = 0; e < NUM_EL; e++) begin : g_el
        assign src_b_eff[e*ELEM_W +: ELEM_W] =
            bcast ? src_b[ELEM_W-1:0] : src_b[e*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/lvi_lane_mix.sv
module lvi_lane_mix
    import lvi_pkg::*;
#(
    parameter int unsigned ELEM_W    = 32,
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned VEC_W    = NUM_LANES*LANE_EL*ELEM_W
) (
    input  logic [VEC_W-1:0] va,
    input  logic [VEC_W-1:0] vb,
    output logic [VEC_W-1:0] mixed
);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int unsigned B = l*LANE_EL;
        assign mixed[(B+0)*ELEM_W +: ELEM_W] = va[(B+0)*ELEM_W +: ELEM_W];
        assign mixed[(B+1)*ELEM_W +: ELEM_W] = vb[(B+0)*ELEM_W +: ELEM_W];
        assign mixed[(B+2)*ELEM_W +: ELEM_W] = va[(B+1)*ELEM_W +: ELEM_W];
        assign mixed[(B+3)*ELEM_W +: ELEM_W] = vb[(B+1)*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/lvi_mask_merge.sv
module lvi_mask_merge
    import lvi_pkg::*;
#(
    parameter int unsigned ELEM_W    = 32,
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned NUM_EL   = NUM_LANES*LANE_EL,
    localparam int unsigned VEC_W    = NUM_EL*ELEM_W
) (
    input  logic [VEC_W-1:0]  mixed,
    input  logic [VEC_W-1:0]  old_dst,
    input  logic [NUM_EL-1:0] wmask,
    input  logic              mask_en,
    input  logic              zero_sel,
    input  logic [1:0]        len_code,
    input  logic              legacy,
    output logic [VEC_W-1:0]  next_data
);

    int unsigned act_lanes;

    always_comb act_lanes = lanes_for(len_code, NUM_LANES);

    for (genvar e = 0; e < NUM_EL; e++) begin : g_el
        localparam int unsigned LN = e / LANE_EL;
        always_comb begin
            if (legacy) begin
                next_data[e*ELEM_W +: ELEM_W] = (LN == 0) ? mixed[e*ELEM_W +: ELEM_W]
                                                          : old_dst[e*ELEM_W +: ELEM_W];
            end else if (LN >= act_lanes) begin
                next_data[e*ELEM_W +: ELEM_W] = '0;
            end else if (!mask_en || wmask[e]) begin
                next_data[e*ELEM_W +: ELEM_W] = mixed[e*ELEM_W +: ELEM_W];
            end else if (zero_sel) begin
                next_data[e*ELEM_W +: ELEM_W] = '0;
            end else begin
                next_data[e*ELEM_W +: ELEM_W] = old_dst[e*ELEM_W +: ELEM_W];
            end
        end
    end

endmodule

// File: rtl/lvi_unit.sv
module lvi_unit
    import lvi_pkg::*;
#(
    parameter int unsigned ELEM_W    = 32,
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned NUM_EL   = NUM_LANES*LANE_EL,
    localparam int unsigned VEC_W    = NUM_EL*ELEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  old_dst,
    input  logic [NUM_EL-1:0] wmask,
    input  logic              mask_en,
    input  logic              zero_sel,
    input  logic              bcast,
    input  logic [1:0]        len_code,
    input  logic              legacy,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data
);

    ctl_state_e       state_q, state_d;
    logic [VEC_W-1:0] b_eff, mixed, next_data;

    lvi_src_prep #(.ELEM_W(ELEM_W), .NUM_EL(NUM_EL)) u_prep (
        .src_b     (src_b),
        .bcast     (bcast & ~legacy),
        .src_b_eff (b_eff)
    );

    lvi_lane_mix #(.ELEM_W(ELEM_W), .NUM_LANES(NUM_LANES)) u_mix (
        .va    (src_a),
        .vb    (b_eff),
        .mixed (mixed)
    );

    lvi_mask_merge #(.ELEM_W(ELEM_W), .NUM_LANES(NUM_LANES)) u_merge (
        .mixed     (mixed),
        .old_dst   (old_dst),
        .wmask     (wmask),
        .mask_en   (mask_en),
        .zero_sel  (zero_sel),
        .len_code  (len_code),
        .legacy    (legacy),
        .next_data (next_data)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst)           out_data <= '0;
        else if (in_valid) out_data <= next_data;
    end

    assign out_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/lvi_unit_chk.sv
module lvi_unit_chk #(
    parameter int unsigned ELEM_W    = 32,
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned NUM_EL   = NUM_LANES*4,
    localparam int unsigned VEC_W    = NUM_EL*ELEM_W,
    localparam int unsigned LANE_W   = 4*ELEM_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              legacy,
    input logic              mask_en,
    input logic              zero_sel,
    input logic [NUM_EL-1:0] wmask,
    input logic [1:0]        len_code,
    input logic [VEC_W-1:0]  old_dst,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_data
);

    // R10
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R5
    zero_all_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && mask_en && zero_sel && wmask == '0) |=> (out_data == '0));

    // R4
    merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && mask_en && !zero_sel && wmask == '0)
        |=> (out_data[LANE_W-1:0] == $past(old_dst[LANE_W-1:0])));

    if (NUM_LANES > 1) begin : g_upper
        // R6
        upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !legacy && len_code == 2'b00) |=> (out_data[VEC_W-1:LANE_W] == '0));

        // R8
        legacy_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && legacy) |=> (out_data[VEC_W-1:LANE_W] == $past(old_dst[VEC_W-1:LANE_W])));
    end

endmodule

bind lvi_unit lvi_unit_chk #(.ELEM_W(ELEM_W), .NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .legacy    (legacy),
    .mask_en   (mask_en),
    .zero_sel  (zero_sel),
    .wmask     (wmask),
    .len_code  (len_code),
    .old_dst   (old_dst),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_lvi_unit.sv
module tb_lvi_unit;

    localparam int EW = 8;
    localparam int NL = 4;
    localparam int NE = NL*4;
    localparam int W  = NE*EW;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  src_a, src_b, old_dst;
    logic [NE-1:0] wmask;
    logic          mask_en, zero_sel, bcast, legacy;
    logic [1:0]    len_code;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lvi_unit #(.ELEM_W(EW), .NUM_LANES(NL)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .old_dst(old_dst), .wmask(wmask), .mask_en(mask_en), .zero_sel(zero_sel),
        .bcast(bcast), .len_code(len_code), .legacy(legacy),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int lanes_of(input logic [1:0] c, input logic leg);
        int n;
        if (leg) return 1;
        n = (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : NL;
        return (n > NL) ? NL : n;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] a, b, od,
                                           input logic [NE-1:0] m,
                                           input logic men, zs, bc, leg,
                                           input logic [1:0] lc);
        logic [W-1:0] r;
        logic [EW-1:0] mx, bv;
        int ln, p, idx, nl;
        nl = lanes_of(lc, leg);
        for (int e = 0; e < NE; e++) begin
            ln  = e / 4;
            p   = e % 4;
            idx = ln*4 + p/2;
            bv  = (bc && !leg) ? b[EW-1:0] : b[idx*EW +: EW];
            mx  = (p % 2 == 0) ? a[idx*EW +: EW] : bv;
            if (leg)               r[e*EW +: EW] = (e < 4) ? mx : od[e*EW +: EW];
            else if (ln >= nl)     r[e*EW +: EW] = '0;
            else if (!men || m[e]) r[e*EW +: EW] = mx;
            else if (zs)           r[e*EW +: EW] = '0;
            else                   r[e*EW +: EW] = od[e*EW +: EW];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] elem_sel(input int lo, input int hi);
        logic [W-1:0] s = '0;
        for (int e = lo; e < hi; e++) s[e*EW +: EW] = '1;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, exp, sel);
        n_chk++;
        if ((got & sel) !== (exp & sel)) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got & sel, exp & sel);
        end
    endtask

    task automatic chk1(input string tag, input logic got, exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic fill(input int s);
        for (int k = 0; k < NE; k++) begin
            src_a[k*EW +: EW]   = 8'h40 ^ 8'((k*17 + s*5) & 255);
            src_b[k*EW +: EW]   = 8'h80 ^ 8'((k*29 + s*3) & 255);
            old_dst[k*EW +: EW] = 8'hC0 ^ 8'((k*11 + s*7) & 255);
        end
    endtask

    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [NE-1:0] pats [8];
        logic [W-1:0]  e, r1;
        int            nl, s;
        string         tag;
        pats = '{16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA,
                 16'h000F, 16'h00F0, 16'h0F0F, 16'h8001};
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst = '0;
        wmask = '0; mask_en = 1'b0; zero_sel = 1'b0; bcast = 1'b0;
        len_code = 2'd0; legacy = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk1("R9 out_valid after reset", out_valid, 1'b0);
        chk("R9 out_data after reset", out_data, '0, '1);
        @(negedge clk) rst = 1'b0;

        s = 0;
        for (int leg = 0; leg < 2; leg++)
        for (int lc = 0; lc < 4; lc++)
        for (int bc = 0; bc < 2; bc++)
        for (int men = 0; men < 2; men++)
        for (int zs = 0; zs < 2; zs++)
        for (int pi = 0; pi < 8; pi++) begin
            @(negedge clk);
            fill(s); s++;
            legacy = 1'(leg); len_code = 2'(lc); bcast = 1'(bc);
            mask_en = 1'(men); zero_sel = 1'(zs); wmask = pats[pi];
            issue();
            e  = model(src_a, src_b, old_dst, wmask, mask_en, zero_sel, bcast, legacy, len_code);
            nl = lanes_of(len_code, legacy);
            if (legacy)        tag = "R8 lane0";
            else if (mask_en)  tag = zero_sel ? "R5 zeroing" : "R4 merging";
            else if (bcast)    tag = "R3 broadcast";
            else               tag = "R1 interleave";
            chk1("R10 out_valid", out_valid, 1'b1);
            chk(tag, out_data, e, elem_sel(0, nl*4));
            if (nl < NL) chk(legacy ? "R8 upper kept" : "R6 upper cleared",
                             out_data, e, elem_sel(nl*4, NE));
        end

        // R2: junk in upper lane elements changes nothing
        @(negedge clk);
        fill(3); legacy = 1'b0; len_code = 2'd3; bcast = 1'b0;
        mask_en = 1'b0; zero_sel = 1'b0; wmask = '0;
        issue();
        r1 = out_data;
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            src_a[(l*4+2)*EW +: 2*EW] = ~src_a[(l*4+2)*EW +: 2*EW];
            src_b[(l*4+2)*EW +: 2*EW] = 16'h5AA5;
        end
        issue();
        chk("R2 upper source elements ignored", out_data, r1, '1);

        // R7: mask bits above active length ignored
        @(negedge clk);
        fill(9); len_code = 2'd0; mask_en = 1'b1; zero_sel = 1'b1; wmask = 16'h0005;
        issue();
        r1 = out_data;
        @(negedge clk) wmask = 16'hFFF5;
        issue();
        chk("R7 high mask bits ignored", out_data, r1, '1);
        chk("R7 result value", out_data,
            model(src_a, src_b, old_dst, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0), '1);

        // R10: drop in_valid, data holds, valid falls
        @(negedge clk) begin in_valid = 1'b0; fill(77); end
        @(posedge clk); #1;
        chk1("R10 out_valid low when idle", out_valid, 1'b0);
        chk("R10 out_data held", out_data, r1, '1);

        // R9: reset while busy
        issue();
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk1("R9 out_valid cleared", out_valid, 1'b0);
        chk("R9 out_data cleared", out_data, '0, '1);
        @(negedge clk) begin rst = 1'b0; in_valid = 1'b0; end

        done = 1'b1;
        finish_run();
    end

endmodule